// File: doc/BRIEF.md
# Boxcar-Filtered Envelope Follower with Amplitude Scaling

The block works on an audio sample tick. Each tick it takes a signed 16-bit input sample into a 32-entry history and keeps a running sum of the last 32 samples. It adds the newest sample and drops the one that has just left the window. Shifting that sum right arithmetically by five gives a moving-average lowpass with a corner near 1 kHz at typical audio rates.

The filtered value is rectified and doubled to an unsigned level. A peak-hold register follows it: it jumps up to any level at or above its current value, and otherwise falls by a fixed step per tick until it rests at zero. When the envelope-enable input is set, an oscillator sample is scaled by this envelope through a signed-by-unsigned multiply. When it is clear, the oscillator sample passes through at half amplitude. All state advances only on a tick, within the tick's own clock edge.

Top module: `boxcar_envelope_vca`

## Requirements
- R1: A sample taken on a tick leaves the running sum exactly 32 ticks later. After 32 ticks of zero input, the filtered value is 0 whatever came before.
- R2: On each tick, the running sum (24-bit signed) gains the new sample and loses the sample taken 32 ticks earlier. `filt_o` shows the sum shifted right arithmetically by 5, from the clock edge of that tick onward.
- R3: A negative filtered value is rectified by bitwise inversion, not negation. A sustained input of -32768 therefore gives a level and envelope of 0xFFFE.
- R4: The level is the rectified value shifted left by one, so the envelope is always even.
- R5: On a tick, if the level is greater than or equal to the stored envelope, the envelope takes the level. Otherwise it drops by 0x10, and it becomes 0 if it held less than 0x10.
- R6: With `env_en_i` = 1, a tick loads `out_o` with bits [31:16] of the signed oscillator sample times the unsigned envelope, using the envelope value of the same tick.
- R7: With `env_en_i` = 0, a tick loads `out_o` with the oscillator sample shifted right arithmetically by one.
- R8: Without a tick, the history, sum, envelope and output keep their values whatever the other inputs do.
- R9: While `rst_n` is low, the history, sum, envelope and output are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sample-rate strobe, one cycle per audio sample |
| sample_i | input | 16 | Signed input sample to be filtered |
| osc_i | input | 16 | Signed oscillator sample to be scaled |
| env_en_i | input | 1 | 1: envelope scaling, 0: half-amplitude bypass |
| filt_o | output | 16 | Signed lowpass output |
| env_o | output | 16 | Unsigned envelope value |
| out_o | output | 16 | Signed registered output sample |

## Verification
The bench builds the block with its defaults: a 32-sample window, a 24-bit sum and a decay step of 0x10. With these values, full-scale positive and negative inputs drive the sum to its extremes within one window. The 0x8000 rectification case and the 0xFFFE envelope ceiling are reached directly. A long run of silence then carries the envelope through several thousand decay steps down to the zero clamp. Random samples with random tick gaps and mode changes compare all three outputs against a queue-based model on every clock.

// File: rtl/bxe_pkg.sv
package bxe_pkg;
    localparam int SAMPLE_W = 16;
    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [SAMPLE_W-1:0]        level_t;

    // ones-complement magnitude doubled into an unsigned level
    function automatic level_t to_level(input sample_t v);
        sample_t mag;
        mag = v[SAMPLE_W-1] ? ~v : v;
        return {mag[SAMPLE_W-2:0], 1'b0};
    endfunction
endpackage

// File: rtl/bxe_delay.sv
module bxe_delay
    import bxe_pkg::*;
#(
    parameter int DEPTH_LOG2 = 5
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  sample_t din,
    output sample_t oldest
);
    localparam int DEPTH = 1 << DEPTH_LOG2;

    typedef struct packed {
        sample_t [DEPTH-1:0]   mem;
        logic [DEPTH_LOG2-1:0] ptr;
    } dl_t;

    dl_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (tick) begin
            nxt_d.mem[cur_q.ptr] = din;
            nxt_d.ptr            = cur_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign oldest = cur_q.mem[cur_q.ptr];

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cur_q.ptr)); // R8
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cur_q.ptr == DEPTH_LOG2'($past(cur_q.ptr) + 1'b1)); // R1
endmodule

// File: rtl/bxe_boxcar.sv
module bxe_boxcar
    import bxe_pkg::*;
#(
    parameter int DEPTH_LOG2 = 5,
    parameter int SUM_W      = 24
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  sample_t din,
    input  sample_t oldest,
    output sample_t filt_now,
    output sample_t filt_next
);
    localparam int EXT_W  = SUM_W - SAMPLE_W;
    localparam int GUARD  = SAMPLE_W + DEPTH_LOG2 - 1;

    logic signed [SUM_W-1:0] sum_q, sum_d;

    always_comb begin
        sum_d = sum_q;
        if (tick)
            sum_d = sum_q + {{EXT_W{din[SAMPLE_W-1]}}, din}
                          - {{EXT_W{oldest[SAMPLE_W-1]}}, oldest};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign filt_now  = sum_q[DEPTH_LOG2 +: SAMPLE_W];
    assign filt_next = sum_d[DEPTH_LOG2 +: SAMPLE_W];

    logic unused_low_bits;
    assign unused_low_bits = ^{sum_q[DEPTH_LOG2-1:0], sum_d[DEPTH_LOG2-1:0],
                               sum_q[SUM_W-1 -: 1], sum_d[SUM_W-1 -: 1]};

    AST_SUM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (&sum_q[SUM_W-1:GUARD]) || !(|sum_q[SUM_W-1:GUARD])); // R2
    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sum_q)); // R8
endmodule

// File: rtl/bxe_envelope.sv
module bxe_envelope
    import bxe_pkg::*;
#(
    parameter int DECAY = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  sample_t filt_next,
    output level_t  env_next,
    output level_t  env_q
);
    level_t level;

    always_comb begin
        level    = to_level(filt_next);
        env_next = env_q;
        if (tick) begin
            if (level >= env_q)             env_next = level;
            else if (env_q < level_t'(DECAY)) env_next = '0;
            else                            env_next = env_q - level_t'(DECAY);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) env_q <= '0;
        else        env_q <= env_next;
    end

    AST_ENV_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (DECAY % 2 != 0) || !env_q[0]); // R4
    AST_ENV_DECAY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (env_q >= $past(env_q)) || (int'($past(env_q)) - int'(env_q) <= DECAY)); // R5
    AST_ENV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(env_q)); // R8
endmodule

// File: rtl/bxe_scale.sv
module bxe_scale
    import bxe_pkg::*;
(
    input  sample_t osc,
    input  level_t  env,
    input  logic    env_en,
    output sample_t result
);
    logic signed [2*SAMPLE_W:0] prod;

    always_comb begin
        prod = $signed(osc) * $signed({1'b0, env});
        if (env_en) result = prod[2*SAMPLE_W-1:SAMPLE_W];
        else        result = osc >>> 1;
    end

    logic unused_prod;
    assign unused_prod = ^{prod[2*SAMPLE_W], prod[SAMPLE_W-1:0]};
endmodule

// File: rtl/boxcar_envelope_vca.sv
module boxcar_envelope_vca
    import bxe_pkg::*;
#(
    parameter int DEPTH_LOG2 = 5,
    parameter int SUM_W      = 24,
    parameter int DECAY      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic [15:0] sample_i,
    input  logic [15:0] osc_i,
    input  logic        env_en_i,
    output logic [15:0] filt_o,
    output logic [15:0] env_o,
    output logic [15:0] out_o
);
    typedef struct packed {
        sample_t out;
    } top_t;

    top_t    st_q, st_d;
    sample_t oldest, filt_now, filt_next, scaled;
    level_t  env_next, env_q;

    bxe_delay #(.DEPTH_LOG2(DEPTH_LOG2)) i_delay (
        .clk(clk), .rst_n(rst_n), .tick(tick_i),
        .din(sample_t'(sample_i)), .oldest(oldest));

    bxe_boxcar #(.DEPTH_LOG2(DEPTH_LOG2), .SUM_W(SUM_W)) i_boxcar (
        .clk(clk), .rst_n(rst_n), .tick(tick_i),
        .din(sample_t'(sample_i)), .oldest(oldest),
        .filt_now(filt_now), .filt_next(filt_next));

    bxe_envelope #(.DECAY(DECAY)) i_env (
        .clk(clk), .rst_n(rst_n), .tick(tick_i),
        .filt_next(filt_next), .env_next(env_next), .env_q(env_q));

    bxe_scale i_scale (
        .osc(sample_t'(osc_i)), .env(env_next), .env_en(env_en_i),
        .result(scaled));

    always_comb begin
        st_d = st_q;
        if (tick_i) st_d.out = scaled;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = filt_now;
    assign env_o  = env_q;
    assign out_o  = st_q.out;

    AST_BYPASS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !env_en_i) |=> $signed(out_o) == ($signed($past(osc_i)) >>> 1)); // R7
    AST_SCALED_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && env_en_i && !osc_i[15]) |=> !out_o[15]); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(out_o)); // R8
endmodule

// File: tb/test_boxcar_envelope_vca.sv
module test_boxcar_envelope_vca;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [15:0] sample_i = '0;
    logic [15:0] osc_i = '0;
    logic        env_en_i = 1'b0;
    logic [15:0] filt_o, env_o, out_o;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // reference model state
    int m_hist[$];
    int m_sum, m_filt, m_env, m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    boxcar_envelope_vca i_boxcar_envelope_vca (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sample_i(sample_i),
        .osc_i(osc_i), .env_en_i(env_en_i),
        .filt_o(filt_o), .env_o(env_o), .out_o(out_o));

    task automatic model_reset();
        m_hist.delete();
        for (int i = 0; i < 32; i++) m_hist.push_back(0);
        m_sum = 0; m_filt = 0; m_env = 0; m_out = 0;
    endtask

    task automatic model_step(input int x, input int osc, input bit en);
        int old, rect, lvl;
        longint p;
        old = m_hist.pop_front();
        m_hist.push_back(x);
        m_sum  = m_sum + x - old;
        m_filt = m_sum >>> 5;
        rect   = (m_filt < 0) ? (-m_filt - 1) : m_filt;
        lvl    = rect * 2;
        if (lvl >= m_env)   m_env = lvl;
        else if (m_env < 16) m_env = 0;
        else                m_env = m_env - 16;
        if (en) begin
            p = longint'(osc) * longint'(m_env);
            m_out = int'(p >>> 16);
        end else begin
            m_out = osc >>> 1;
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        string tf, te, to;
        tf = (tag != "") ? tag : "R2";
        te = (tag != "") ? tag : "R5";
        to = (tag != "") ? tag : (env_en_i ? "R6" : "R7");
        check({tf, " filt"}, int'($signed(filt_o)), m_filt);
        check({te, " env"},  int'(env_o),           m_env);
        check({to, " out"},  int'($signed(out_o)),  m_out);
    endtask

    // drive at negedge, compare at the following negedge
    task automatic apply(input bit t, input int x, input int osc, input bit en,
                         input string tag);
        tick_i   = t;
        sample_i = 16'(x);
        osc_i    = 16'(osc);
        env_en_i = en;
        if (t) model_step(x, osc, en);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        tick_i = 1'b1;
        sample_i = 16'h1234;
        repeat (3) @(negedge clk);
        model_reset();
        check_all("R9");
        rst_n  = 1'b1;
        tick_i = 1'b0;
    endtask

    initial begin
        model_reset();
        do_reset();

        // positive full scale: envelope climbs to the ceiling
        for (int i = 0; i < 40; i++) apply(1'b1, 32767, 16384, 1'b1, "");

        // no tick: everything holds while inputs move (R8)
        for (int i = 0; i < 6; i++) apply(1'b0, -1000 * i, 777 * i, i[0], "R8");

        // negative full scale: 0x8000 rectification (R3), scaled output (R6)
        for (int i = 0; i < 40; i++) apply(1'b1, -32768, -32768, 1'b1, "");
        check("R3 env ceiling", int'(env_o), 65534);
        check("R6 out min", int'($signed(out_o)), -32767);

        // silence: window empties after 32 ticks (R1)
        for (int i = 0; i < 32; i++) apply(1'b1, 0, 12345, 1'b1, "");
        check("R1 filt empty", int'($signed(filt_o)), 0);

        // long silence: envelope decays to the clamp (R5)
        for (int i = 0; i < 4200; i++) apply(1'b1, 0, -20000, 1'b1, "");
        check("R5 env clamp", int'(env_o), 0);

        // bypass halves with arithmetic shift (R7)
        apply(1'b1, 0, -3, 1'b0, "");
        check("R7 bypass", int'($signed(out_o)), -2);

        // random samples, tick gaps and mode changes
        for (int i = 0; i < 2000; i++) begin
            int x, o;
            bit t, en;
            x  = int'($signed(16'($urandom())));
            o  = int'($signed(16'($urandom())));
            t  = ($urandom() % 4) != 0;
            en = ($urandom() % 3) != 0;
            apply(t, x, o, en, "");
            check("R4 env even", int'(env_o[0]), 0);
        end

        // reset in mid-run (R9)
        do_reset();
        apply(1'b1, 100, 200, 1'b1, "");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule